// File: doc/BRIEF.md
# Data-Strobe Serial Transmit Encoder

This block turns bytes from the link side into a serial data-strobe line pair for one attached peer port. It sends one bit per transmit clock. The data line carries the bit value. The strobe line changes only when the data line does not, so the XOR of the two lines recovers the bit clock at the far end. The encoder's own record of the last data and strobe values is kept from one byte to the next and from one packet to the next. Gaps, resets and blocked bytes leave that record alone.

The same link-side interface also carries two arbitration line states: an idle gap and a bus-reset indication. Both take priority over packet data and cut short any byte that is being sent. Every byte comes with a speed code. If that code is above the port's maximum speed code, the byte's bit periods are spent with the pair held in the data-prefix state, and no data bits go out.

Top module: `ds_tx_encoder`

## Requirements
- R1: After reset, `ds_data` and `ds_strobe` are both 0 and `tx_ready` is 1.
- R2: A byte is taken at the clock edge where `tx_valid` and `tx_ready` are both high. Its bits leave most-significant first, one per clock. The first bit is on the lines after the next edge.
- R3: For each sent bit, `ds_data` equals the bit. `ds_strobe` toggles only when the bit equals the previous sent data bit. Between two consecutive sent bits, exactly one of the two lines changes.
- R4: The previous-bit record used by R3 carries over across idle time, gaps, bus resets and blocked bytes. Only sent data bits update it.
- R5: `tx_ready` is 0 for the 8 clocks after a byte is taken. It is 1 again in the cycle the last bit is on the lines.
- R6: A speed code is 2 bits: 0 means 100, 1 means 200 and 2 means 400 Mbit/s. A byte is sent only when `tx_speed` is less than or equal to `port_max_speed`.
- R7: A byte refused under R6 still takes its 8 bit periods. During them the lines are `ds_data`=0 and `ds_strobe`=1 (the data-prefix state).
- R8: While `bus_rst_req` is high, from the next clock the lines are 1,1 and `tx_ready` is 0. Any byte in progress is dropped.
- R9: While `gap_req` is high and `bus_rst_req` is low, from the next clock the lines are 0,0 and `tx_ready` is 0. Any byte in progress is dropped.
- R10: With no byte in progress and no request, the lines keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_speed | input | 2 | Requested speed code of the byte |
| port_max_speed | input | 2 | Highest speed code the attached port accepts |
| gap_req | input | 1 | Drive the idle gap state |
| bus_rst_req | input | 1 | Drive the bus-reset state |
| ds_data | output | 1 | Serial data line |
| ds_strobe | output | 1 | Serial strobe line |
| tx_ready | output | 1 | Encoder can take a byte |

## Verification
Bit k of a byte taken at edge E is on the lines after edge E+1+k. The bench drives inputs on the falling edge and samples each bit on the falling edge after the edge that registered it. `tx_ready` drops at the edge that takes the byte. The bench reads it in the half cycle after that edge and again on each bit's falling edge: it expects 0 for bits 0 to 6 and 1 for bit 7. Gap and reset states show one edge after the request. `tx_ready` depends on the request inputs directly, so the bench reads it shortly after changing them.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
   typedef enum logic [2:0] {
      SEL_HOLD   = 3'd0,
      SEL_DATA   = 3'd1,
      SEL_PREFIX = 3'd2,
      SEL_GAP    = 3'd3,
      SEL_RESET  = 3'd4
   } line_sel_e;
endpackage

// File: rtl/ds_spd_gate.sv
module ds_spd_gate #(
   parameter int SPD_W = 2
) (
   input  logic [SPD_W-1:0] req_code,
   input  logic [SPD_W-1:0] max_code,
   output logic             spd_ok
);
   always_comb spd_ok = (req_code <= max_code);
endmodule

// File: rtl/ds_shifter.sv
module ds_shifter #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              load_blk,
   input  logic              abort,
   output logic              cur_bit,
   output logic              cur_blk,
   output logic              busy
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              blk_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = sh_q[BYTE_W-1];
         assign sh_nxt  = {sh_q[BYTE_W-2:0], 1'b0};
      end else begin : g_lsb
         assign cur_bit = sh_q[0];
         assign sh_nxt  = {1'b0, sh_q[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else if (abort) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else if (load) begin
         sh_q  <= load_byte;
         cnt_q <= CNT_FULL;
         blk_q <= load_blk;
      end else if (cnt_q != '0) begin
         sh_q  <= sh_nxt;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy    = (cnt_q != '0);
   assign cur_blk = blk_q & busy;
endmodule

// File: rtl/ds_line_enc.sv
module ds_line_enc
   import ds_tx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  line_sel_e sel,
   input  logic      bit_in,
   output logic      ds_data,
   output logic      ds_strobe,
   output logic      was_data
);
   logic prev_d_q;
   logic prev_s_q;
   logic nxt_s;

   always_comb nxt_s = (bit_in == prev_d_q) ? ~prev_s_q : prev_s_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ds_data   <= 1'b0;
         ds_strobe <= 1'b0;
         prev_d_q  <= 1'b0;
         prev_s_q  <= 1'b0;
         was_data  <= 1'b0;
      end else begin
         was_data <= (sel == SEL_DATA);
         case (sel)
            SEL_DATA: begin
               ds_data   <= bit_in;
               ds_strobe <= nxt_s;
               prev_d_q  <= bit_in;
               prev_s_q  <= nxt_s;
            end
            SEL_PREFIX: begin
               ds_data   <= 1'b0;
               ds_strobe <= 1'b1;
            end
            SEL_GAP: begin
               ds_data   <= 1'b0;
               ds_strobe <= 1'b0;
            end
            SEL_RESET: begin
               ds_data   <= 1'b1;
               ds_strobe <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
   import ds_tx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int SPD_W     = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_valid,
   input  logic [SPD_W-1:0]  tx_speed,
   input  logic [SPD_W-1:0]  port_max_speed,
   input  logic              gap_req,
   input  logic              bus_rst_req,
   output logic              ds_data,
   output logic              ds_strobe,
   output logic              tx_ready
);
   generate
      if (BYTE_W < 2) begin : g_bad_byte_w
         $error("ds_tx_encoder: BYTE_W must be at least 2");
      end
      if (SPD_W < 1) begin : g_bad_spd_w
         $error("ds_tx_encoder: SPD_W must be at least 1");
      end
   endgenerate

   logic      spd_ok;
   logic      cur_bit;
   logic      cur_blk;
   logic      busy;
   logic      abort;
   logic      take;
   logic      enc_was_data;
   line_sel_e line_sel;

   assign abort    = bus_rst_req | gap_req;
   assign tx_ready = ~busy & ~abort;
   assign take     = tx_valid & tx_ready;

   ds_spd_gate #(.SPD_W(SPD_W)) u_gate (
      .req_code (tx_speed),
      .max_code (port_max_speed),
      .spd_ok   (spd_ok)
   );

   ds_shifter #(.BYTE_W(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .load_byte (tx_byte),
      .load_blk  (~spd_ok),
      .abort     (abort),
      .cur_bit   (cur_bit),
      .cur_blk   (cur_blk),
      .busy      (busy)
   );

   always_comb begin
      if (bus_rst_req)  line_sel = SEL_RESET;
      else if (gap_req) line_sel = SEL_GAP;
      else if (busy)    line_sel = cur_blk ? SEL_PREFIX : SEL_DATA;
      else              line_sel = SEL_HOLD;
   end

   ds_line_enc u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (line_sel),
      .bit_in    (cur_bit),
      .ds_data   (ds_data),
      .ds_strobe (ds_strobe),
      .was_data  (enc_was_data)
   );
endmodule

// File: rtl/ds_tx_chk.sv
module ds_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic gap_req,
   input logic bus_rst_req,
   input logic ds_data,
   input logic ds_strobe,
   input logic cur_blk,
   input logic enc_was_data
);
   // R3
   one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_was_data && $past(enc_was_data) |->
         $countones({ds_data ^ $past(ds_data), ds_strobe ^ $past(ds_strobe)}) == 1);

   // R8
   rst_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_req |=> (ds_data && ds_strobe));

   // R9
   gap_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_req && !bus_rst_req |=> (!ds_data && !ds_strobe));

   // R5
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);

   // R7
   prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_blk && !gap_req && !bus_rst_req |=> (!ds_data && ds_strobe));
endmodule

bind ds_tx_encoder ds_tx_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .gap_req      (gap_req),
   .bus_rst_req  (bus_rst_req),
   .ds_data      (ds_data),
   .ds_strobe    (ds_strobe),
   .cur_blk      (cur_blk),
   .enc_was_data (enc_was_data)
);

// File: tb/sim_ds_tx_encoder.sv
`timescale 1ns/1ps
module sim_ds_tx_encoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       tx_valid = 1'b0;
   logic [1:0] tx_speed = '0;
   logic [1:0] port_max_speed = '0;
   logic       gap_req = 1'b0;
   logic       bus_rst_req = 1'b0;
   logic       ds_data, ds_strobe, tx_ready;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic m_d = 1'b0;
   logic m_s = 1'b0;

   always #2.5 clk = ~clk;

   ds_tx_encoder u0 (
      .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
      .tx_speed(tx_speed), .port_max_speed(port_max_speed),
      .gap_req(gap_req), .bus_rst_req(bus_rst_req),
      .ds_data(ds_data), .ds_strobe(ds_strobe), .tx_ready(tx_ready)
   );

   // {byte, speed code, port max code}
   localparam logic [11:0] VEC [7] = '{
      {8'hA5, 2'd0, 2'd2}, {8'h00, 2'd1, 2'd1}, {8'hFF, 2'd2, 2'd2},
      {8'h5A, 2'd2, 2'd1}, {8'h81, 2'd0, 2'd0}, {8'h96, 2'd3, 2'd2},
      {8'h3C, 2'd1, 2'd2}
   };

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic model_bit(input logic b);
      if (b == m_d) m_s = ~m_s;
      m_d = b;
   endtask

   task automatic one_bit(input logic b, input logic ok);
      @(negedge clk);
      if (ok) begin
         model_bit(b);
         chk("R2/R3/R4 bit", {ds_data, ds_strobe}, {m_d, m_s});
      end else begin
         chk("R6/R7 prefix", {ds_data, ds_strobe}, 2'b01);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic [1:0] sp, input logic [1:0] mx);
      logic ok;
      ok = (sp <= mx);
      tx_byte = b; tx_speed = sp; port_max_speed = mx; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R5 ready low after take", {1'b0, tx_ready}, 2'b00);
      for (int k = 7; k >= 0; k--) begin
         one_bit(b[k], ok);
         chk("R5 ready during bits", {1'b0, tx_ready}, (k == 0) ? 2'b01 : 2'b00);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 lines", {ds_data, ds_strobe}, 2'b00);
      chk("R1 ready", {1'b0, tx_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after release", {1'b0, tx_ready}, 2'b01);

      foreach (VEC[i]) send_byte(VEC[i][11:4], VEC[i][3:2], VEC[i][1:0]);

      // R10 idle holds last line values
      begin
         logic [1:0] held;
         held = {ds_data, ds_strobe};
         repeat (3) @(negedge clk);
         chk("R10 idle hold", {ds_data, ds_strobe}, held);
      end

      // R8 bus reset cuts a byte short after 3 bits
      tx_byte = 8'hC6; tx_speed = 2'd0; port_max_speed = 2'd2; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      one_bit(1'b1, 1'b1);
      one_bit(1'b1, 1'b1);
      one_bit(1'b0, 1'b1);
      bus_rst_req = 1'b1;
      #1 chk("R8 ready low", {1'b0, tx_ready}, 2'b00);
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         chk("R8 reset lines", {ds_data, ds_strobe}, 2'b11);
         chk("R8 ready held low", {1'b0, tx_ready}, 2'b00);
      end
      bus_rst_req = 1'b0;
      #1 chk("R8 byte dropped, ready", {1'b0, tx_ready}, 2'b01);
      @(negedge clk);
      chk("R10 hold after reset", {ds_data, ds_strobe}, 2'b11);

      // R9 gap, reset overrides gap
      gap_req = 1'b1;
      @(negedge clk);
      chk("R9 gap lines", {ds_data, ds_strobe}, 2'b00);
      chk("R9 ready low", {1'b0, tx_ready}, 2'b00);
      bus_rst_req = 1'b1;
      @(negedge clk);
      chk("R8 reset over gap", {ds_data, ds_strobe}, 2'b11);
      bus_rst_req = 1'b0;
      @(negedge clk);
      chk("R9 gap again", {ds_data, ds_strobe}, 2'b00);
      gap_req = 1'b0;

      // R4 record continues from the dropped byte's three sent bits
      send_byte(8'h69, 2'd2, 2'd2);
      // R9 gap drops a byte in progress
      tx_byte = 8'hF0; tx_speed = 2'd1; port_max_speed = 2'd1; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      one_bit(1'b1, 1'b1);
      gap_req = 1'b1;
      @(negedge clk);
      chk("R9 gap mid byte", {ds_data, ds_strobe}, 2'b00);
      gap_req = 1'b0;
      #1 chk("R9 ready after gap", {1'b0, tx_ready}, 2'b01);
      // R4 and R7: blocked byte then sent byte
      send_byte(8'h0F, 2'd2, 2'd0);
      send_byte(8'h0F, 2'd2, 2'd2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule